// File: doc/BRIEF.md
# PHY Test-Port Access Sequencer

This block sits between a register-style request source and the serial test/configuration port of a physical-layer macro. Each accepted request is a write, a read, or a port-clear command. The block expands it into a fixed series of pin changes on that port: a strobe clock, an address-enable, an 8-bit data-in bus and a clear line. It also samples the port's 8-bit data-out bus. Every pin change is followed by a programmable settling wait, counted in system clock cycles by one shared down-counter.

A write has two phases. The code phase places the test code on the bus and latches it into the PHY on the falling strobe edge while the enable is high. The data phase then commits the data byte on the rising strobe edge. A read runs the same code phase and captures the data-out byte. Its data phase writes that byte back unchanged, so the PHY register keeps its value. A request that names a test code above the highest legal code completes at once with an error and leaves the port untouched.

Top module: `phy_tif_master`

## Requirements
- R1: During and directly after reset, req_ready is 1 and tst_clk, tst_en, tst_clr, tst_din, rsp_done and rsp_error are all 0.
- R2: A write or read request whose req_code is above 0x97 gives rsp_done=1 and rsp_error=1 in the cycle after acceptance. No port pin changes, and req_ready stays 1. Code 0x97 itself is legal.
- R3: req_op encoding: 2'b00 is a write, 2'b01 is a read, and 2'b1x is a clear. A write applies these steps in this order: tst_clr low, tst_clk high, tst_din = code, tst_en high, tst_clk low, tst_en low, tst_clk low, tst_din = data, tst_clk high.
- R4: tst_en rises only while tst_clk is high and falls only while tst_clk is low, so the code is latched on a falling strobe edge with the enable high.
- R5: A read samples tst_dout at the end of the enable-low step. It uses the write step order, with the sampled byte as the data. It returns that byte on rsp_rdata in the rsp_done cycle.
- R6: A clear applies these steps: tst_clk and tst_clr low, then tst_clr high, then tst_clr low. It never range-checks req_code and never reports an error.
- R7: req_ready drops in the cycle after acceptance and stays low until the completion cycle. rsp_done is a one-cycle pulse in that cycle with req_ready high again. rsp_error is only ever high with rsp_done. rsp_rdata is 0 on completion of writes, clears and rejected requests.
- R8: Each step holds for exactly SETTLE_CYCLES clock cycles. No two port pin changes are closer than SETTLE_CYCLES cycles apart.
- R9: While idle with no request, the port pins hold their last values. tst_clk is left high after a write or read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Idle, can accept a request |
| req_op | input | 2 | 00 write, 01 read, 1x clear |
| req_code | input | 8 | Test code (PHY register address) |
| req_wdata | input | 8 | Write data byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Request rejected for an out-of-range code |
| rsp_rdata | output | 8 | Byte read, valid with rsp_done |
| tst_clk | output | 1 | Test-port strobe clock |
| tst_en | output | 1 | Test-port code enable |
| tst_din | output | 8 | Test-port data-in bus |
| tst_clr | output | 1 | Test-port clear |
| tst_dout | input | 8 | Test-port data-out bus |

## Verification
The bench keeps a small behavioural PHY that latches codes on falling strobe edges and commits bytes on rising ones. A read that captured tst_dout at the wrong step, or wrote back a different byte, would therefore show up as a wrong read-back value later. The per-cycle reference trace catches several faults:
- a step sequence that swaps the enable and strobe edges;
- a settling window one cycle short or long;
- a boundary test that rejects code 0x97 or accepts 0x98;
- a clear that tests its code field.

Idle stretches check that the strobe is left high after an access and that nothing moves without a request.

// File: rtl/phy_tif_pkg.sv
package phy_tif_pkg;

    localparam int unsigned TIF_CODE_W = 8;
    localparam int unsigned TIF_DATA_W = 8;

    typedef enum logic [1:0] {
        OP_WRITE     = 2'b00,
        OP_READ      = 2'b01,
        OP_CLEAR     = 2'b10,
        OP_CLEAR_ALT = 2'b11
    } tif_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLR_LO,
        ST_CK_HI,
        ST_PUT_CODE,
        ST_EN_HI,
        ST_CK_LO,
        ST_EN_LO,
        ST_D_CK_LO,
        ST_PUT_DATA,
        ST_D_CK_HI,
        ST_CL_ZERO,
        ST_CL_SET,
        ST_CL_DROP
    } tif_step_e;

    typedef struct packed {
        logic                  ck;
        logic                  en;
        logic                  clr;
        logic [TIF_DATA_W-1:0] din;
    } tif_pins_t;

    typedef struct packed {
        tif_op_e               op;
        logic [TIF_CODE_W-1:0] code;
        logic [TIF_DATA_W-1:0] data;
    } tif_req_t;

    function automatic logic op_is_clear(tif_op_e op);
        return op[1];
    endfunction

    function automatic tif_step_e first_step(tif_op_e op);
        return op_is_clear(op) ? ST_CL_ZERO : ST_CLR_LO;
    endfunction

    function automatic tif_step_e next_step(tif_step_e s);
        tif_step_e n;
        case (s)
            ST_CLR_LO:   n = ST_CK_HI;
            ST_CK_HI:    n = ST_PUT_CODE;
            ST_PUT_CODE: n = ST_EN_HI;
            ST_EN_HI:    n = ST_CK_LO;
            ST_CK_LO:    n = ST_EN_LO;
            ST_EN_LO:    n = ST_D_CK_LO;
            ST_D_CK_LO:  n = ST_PUT_DATA;
            ST_PUT_DATA: n = ST_D_CK_HI;
            ST_CL_ZERO:  n = ST_CL_SET;
            ST_CL_SET:   n = ST_CL_DROP;
            default:     n = ST_IDLE;
        endcase
        return n;
    endfunction

    function automatic tif_pins_t apply_step(tif_step_e s, tif_pins_t p,
                                             logic [TIF_CODE_W-1:0] code,
                                             logic [TIF_DATA_W-1:0] data);
        tif_pins_t r;
        r = p;
        case (s)
            ST_CLR_LO:   r.clr = 1'b0;
            ST_CK_HI:    r.ck  = 1'b1;
            ST_PUT_CODE: r.din = TIF_DATA_W'(code);
            ST_EN_HI:    r.en  = 1'b1;
            ST_CK_LO:    r.ck  = 1'b0;
            ST_EN_LO:    r.en  = 1'b0;
            ST_D_CK_LO:  r.ck  = 1'b0;
            ST_PUT_DATA: r.din = data;
            ST_D_CK_HI:  r.ck  = 1'b1;
            ST_CL_ZERO: begin
                r.ck  = 1'b0;
                r.clr = 1'b0;
            end
            ST_CL_SET:   r.clr = 1'b1;
            ST_CL_DROP:  r.clr = 1'b0;
            default:     r = p;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tif_req_check.sv
module tif_req_check
    import phy_tif_pkg::*;
#(
    parameter logic [TIF_CODE_W-1:0] CODE_MAX = 8'h97
) (
    input  tif_op_e               op_i,
    input  logic [TIF_CODE_W-1:0] code_i,
    output logic                  legal_o
);
    always_comb begin
        legal_o = op_is_clear(op_i) || (code_i <= CODE_MAX);
    end
endmodule

// File: rtl/tif_settle_timer.sv
module tif_settle_timer #(
    parameter int unsigned SETTLE_CYCLES = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic expired_o
);
    localparam int unsigned CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(SETTLE_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/tif_step_seq.sv
module tif_step_seq
    import phy_tif_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid_i,
    input  tif_req_t              req_i,
    input  logic                  req_legal_i,
    output logic                  req_ready_o,
    output logic                  timer_load_o,
    input  logic                  timer_expired_i,
    input  logic [TIF_DATA_W-1:0] dout_i,
    output tif_pins_t             pins_o,
    output logic                  done_o,
    output logic                  error_o,
    output logic [TIF_DATA_W-1:0] rdata_o
);
    tif_step_e             step_q;
    tif_req_t              cur_q;
    tif_pins_t             pins_q;
    logic                  done_q;
    logic                  err_q;
    logic [TIF_DATA_W-1:0] rdata_q;

    logic      idle;
    logic      accept;
    tif_step_e nxt;

    always_comb begin
        idle         = (step_q == ST_IDLE);
        accept       = idle && req_valid_i;
        nxt          = next_step(step_q);
        timer_load_o = (accept && req_legal_i) ||
                       (!idle && timer_expired_i && (nxt != ST_IDLE));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q  <= ST_IDLE;
            cur_q   <= '0;
            pins_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (accept) begin
                if (!req_legal_i) begin
                    done_q  <= 1'b1;
                    err_q   <= 1'b1;
                    rdata_q <= '0;
                end else begin
                    cur_q  <= req_i;
                    step_q <= first_step(req_i.op);
                    pins_q <= apply_step(first_step(req_i.op), pins_q,
                                         req_i.code, req_i.data);
                end
            end else if (!idle && timer_expired_i) begin
                if (step_q == ST_EN_LO && cur_q.op == OP_READ) begin
                    cur_q.data <= dout_i;
                end
                step_q <= nxt;
                if (nxt == ST_IDLE) begin
                    done_q  <= 1'b1;
                    rdata_q <= (cur_q.op == OP_READ) ? cur_q.data : '0;
                end else begin
                    pins_q <= apply_step(nxt, pins_q, cur_q.code, cur_q.data);
                end
            end
        end
    end

    assign req_ready_o = idle;
    assign pins_o      = pins_q;
    assign done_o      = done_q;
    assign error_o     = err_q;
    assign rdata_o     = rdata_q;
endmodule

// File: rtl/phy_tif_master.sv
module phy_tif_master
    import phy_tif_pkg::*;
#(
    parameter int unsigned           SETTLE_CYCLES = 50,
    parameter logic [TIF_CODE_W-1:0] CODE_MAX      = 8'h97
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [1:0]            req_op,
    input  logic [TIF_CODE_W-1:0] req_code,
    input  logic [TIF_DATA_W-1:0] req_wdata,
    output logic                  rsp_done,
    output logic                  rsp_error,
    output logic [TIF_DATA_W-1:0] rsp_rdata,
    output logic                  tst_clk,
    output logic                  tst_en,
    output logic [TIF_DATA_W-1:0] tst_din,
    output logic                  tst_clr,
    input  logic [TIF_DATA_W-1:0] tst_dout
);
    localparam int unsigned GW      = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) + 1 : 2;
    localparam int          GAP_MIN = int'(SETTLE_CYCLES) - 1;

    tif_req_t  req_s;
    logic      legal;
    logic      t_load;
    logic      t_exp;
    tif_pins_t pins;

    always_comb begin
        req_s.op   = tif_op_e'(req_op);
        req_s.code = req_code;
        req_s.data = req_wdata;
    end

    tif_req_check #(.CODE_MAX(CODE_MAX)) u_check (
        .op_i    (req_s.op),
        .code_i  (req_code),
        .legal_o (legal)
    );

    tif_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load_i    (t_load),
        .expired_o (t_exp)
    );

    tif_step_seq u_seq (
        .clk             (clk),
        .rst             (rst),
        .req_valid_i     (req_valid),
        .req_i           (req_s),
        .req_legal_i     (legal),
        .req_ready_o     (req_ready),
        .timer_load_o    (t_load),
        .timer_expired_i (t_exp),
        .dout_i          (tst_dout),
        .pins_o          (pins),
        .done_o          (rsp_done),
        .error_o         (rsp_error),
        .rdata_o         (rsp_rdata)
    );

    assign tst_clk = pins.ck;
    assign tst_en  = pins.en;
    assign tst_clr = pins.clr;
    assign tst_din = pins.din;

    // Gap tracker for the settle-window check
    tif_pins_t     pins_prev;
    logic [GW-1:0] since_chg;
    logic          pins_moved;

    assign pins_moved = (pins != pins_prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_prev <= '0;
            since_chg <= '1;
        end else begin
            pins_prev <= pins;
            if (pins_moved) begin
                since_chg <= '0;
            end else if (since_chg != '1) begin
                since_chg <= since_chg + 1'b1;
            end
        end
    end

    // R4
    en_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tst_en) |-> tst_clk);
    // R4
    en_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tst_en) |-> !tst_clk);
    // R7
    err_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_error |-> rsp_done);
    // R7
    no_done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> !rsp_done);
    // R7
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(req_ready) |-> $past(req_valid));
    // R8
    settle_gap_chk: assert property (@(posedge clk) disable iff (rst)
        pins_moved |-> (int'(since_chg) >= GAP_MIN));
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(req_ready && !req_valid) |-> $stable(pins));
    // R2
    reject_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && req_ready && !req_op[1] && (req_code > CODE_MAX))
        |-> ($stable(pins) && req_ready && rsp_error));
    // R6
    clear_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && req_ready && req_op[1]) |=> !rsp_error);
endmodule

// File: tb/phy_tif_master_bench.sv
module phy_tif_master_bench;
    localparam int S = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_op = 2'b00;
    logic [7:0] req_code = 8'h00;
    logic [7:0] req_wdata = 8'h00;
    logic       rsp_done, rsp_error;
    logic [7:0] rsp_rdata;
    logic       tst_clk, tst_en, tst_clr;
    logic [7:0] tst_din, tst_dout;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    phy_tif_master #(.SETTLE_CYCLES(S)) u_phy_tif_master (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_code(req_code), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
        .tst_clk(tst_clk), .tst_en(tst_en), .tst_din(tst_din),
        .tst_clr(tst_clr), .tst_dout(tst_dout)
    );

    // Behavioural PHY: code on falling strobe with enable, data on rising strobe without
    logic [7:0] phy_mem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] phy_code = 8'h00;
    logic       prev_ck = 1'b0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            phy_mem[i] = (i == 0) ? 8'h00 : 8'(i * 29 + 7);
            exp_mem[i] = (i == 0) ? 8'h00 : 8'(i * 29 + 7);
        end
    end

    always @(posedge clk) begin
        prev_ck <= tst_clk;
        if (prev_ck && !tst_clk && tst_en) phy_code <= tst_din;
        if (!prev_ck && tst_clk && !tst_en) phy_mem[phy_code] <= tst_din;
    end
    assign tst_dout = phy_mem[phy_code];

    // Reference trace
    typedef struct {
        logic       ck, en, clr;
        logic [7:0] din;
        logic       rdy, dn, er;
        logic [7:0] rd;
        string      tag;
    } exp_t;

    exp_t q[$];
    logic       m_ck = 0, m_en = 0, m_clr = 0;
    logic [7:0] m_din = 8'h00;

    task automatic push_step(string tag);
        exp_t e;
        e.ck = m_ck; e.en = m_en; e.clr = m_clr; e.din = m_din;
        e.rdy = 1'b0; e.dn = 1'b0; e.er = 1'b0; e.rd = 8'h00;
        e.tag = {tag, "/R8"};
        for (int k = 0; k < S; k++) q.push_back(e);
    endtask

    task automatic push_done(logic [7:0] rd, logic er, string tag);
        exp_t e;
        e.ck = m_ck; e.en = m_en; e.clr = m_clr; e.din = m_din;
        e.rdy = 1'b1; e.dn = 1'b1; e.er = er; e.rd = rd;
        e.tag = {tag, "/R7"};
        q.push_back(e);
    endtask

    task automatic tick();
        exp_t e;
        @(negedge clk);
        if (q.size() > 0) begin
            e = q.pop_front();
        end else begin
            e.ck = m_ck; e.en = m_en; e.clr = m_clr; e.din = m_din;
            e.rdy = 1'b1; e.dn = 1'b0; e.er = 1'b0; e.rd = 8'h00;
            e.tag = "R9";
        end
        compared++;
        if (tst_clk !== e.ck || tst_en !== e.en || tst_clr !== e.clr ||
            tst_din !== e.din || req_ready !== e.rdy || rsp_done !== e.dn ||
            rsp_error !== e.er || (e.dn && rsp_rdata !== e.rd)) begin
            mismatched++;
            $display("FAIL %s t=%0t: got ck=%b en=%b clr=%b din=%h rdy=%b dn=%b er=%b rd=%h exp ck=%b en=%b clr=%b din=%h rdy=%b dn=%b er=%b rd=%h",
                     e.tag, $time, tst_clk, tst_en, tst_clr, tst_din, req_ready,
                     rsp_done, rsp_error, rsp_rdata, e.ck, e.en, e.clr, e.din,
                     e.rdy, e.dn, e.er, e.rd);
        end
    endtask

    task automatic run_req(logic [1:0] op, logic [7:0] code, logic [7:0] data, string tag);
        logic [7:0] rv;
        req_op = op; req_code = code; req_wdata = data; req_valid = 1'b1;
        if (op[1]) begin
            m_ck = 0; m_clr = 0; push_step(tag);
            m_clr = 1; push_step(tag);
            m_clr = 0; push_step(tag);
            push_done(8'h00, 1'b0, tag);
        end else if (code > 8'h97) begin
            push_done(8'h00, 1'b1, tag);
        end else begin
            rv = exp_mem[code];
            m_clr = 0; push_step(tag);
            m_ck = 1; push_step(tag);
            m_din = code; push_step(tag);
            m_en = 1; push_step(tag);
            m_ck = 0; push_step(tag);
            m_en = 0; push_step(tag);
            m_ck = 0; push_step(tag);
            m_din = (op == 2'b00) ? data : rv; push_step(tag);
            m_ck = 1; push_step(tag);
            if (op == 2'b00) exp_mem[code] = data;
            push_done((op == 2'b01) ? rv : 8'h00, 1'b0, tag);
        end
        tick();
        req_valid = 1'b0;
        while (q.size() > 0) tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        compared++;
        if (req_ready !== 1'b1 || tst_clk !== 0 || tst_en !== 0 || tst_clr !== 0 ||
            tst_din !== 8'h00 || rsp_done !== 0 || rsp_error !== 0) begin
            mismatched++;
            $display("FAIL R1: got rdy=%b ck=%b en=%b clr=%b din=%h dn=%b er=%b exp rdy=1 rest 0",
                     req_ready, tst_clk, tst_en, tst_clr, tst_din, rsp_done, rsp_error);
        end
        rst = 1'b0;
        tick(); tick();                         // R1 idle after release
        run_req(2'b00, 8'h10, 8'hA5, "R3/R4");   // write
        run_req(2'b01, 8'h10, 8'h00, "R5");      // read back written byte
        run_req(2'b01, 8'h44, 8'h00, "R5");      // read untouched register
        repeat (6) tick();                      // R9 idle, strobe left high
        run_req(2'b00, 8'h97, 8'h3C, "R2");      // highest legal code
        run_req(2'b01, 8'h97, 8'h00, "R2/R5");
        run_req(2'b00, 8'h98, 8'h55, "R2");      // rejected
        run_req(2'b01, 8'hFF, 8'h00, "R2");      // rejected
        run_req(2'b10, 8'hFF, 8'h00, "R6");      // clear ignores code range
        run_req(2'b11, 8'h20, 8'h00, "R6");
        run_req(2'b00, 8'h18, 8'h0F, "R3");
        run_req(2'b00, 8'h18, 8'hF0, "R3");
        run_req(2'b01, 8'h18, 8'h00, "R5");      // last write wins
        run_req(2'b01, 8'h00, 8'h00, "R5");
        repeat (5) tick();                      // R9
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule